// File: doc/BRIEF.md
# Posit Multiplier

This block multiplies two posit numbers of width `N` with `ES` exponent bits and returns a posit of the same format. Each operand is unpacked into a sign, a combined power-of-two scale and a fraction. The unpacking finds the run of identical leading bits that sets the coarse scale, so the fields start at positions that depend on the value. The product sign is the exclusive-or of the operand signs. The product scale is the sum of the operand scales. The fractions, each with its implied leading one, are multiplied as fixed-point numbers. The product is then renormalised, and a barrel shifter builds the output bit pattern. Rounding happens once, at that final step.

The two special codes are handled ahead of the arithmetic. The pattern with only the top bit set means "not a real" and wins over everything else. The all-zero pattern is zero. Operands enter on a valid/ready handshake. A parameter selects either a purely combinational path or a single output register that is held while the consumer stalls.

Top module: `posit_mul`

## Requirements
- R1: For two operands that are neither zero nor the not-a-real pattern, the result's top bit (sign) equals the exclusive-or of the operands' top bits.
- R2: If either operand is the not-a-real pattern (only bit N-1 set, 0x80 for N=8), the result is that same pattern.
- R3: If neither operand is not-a-real and at least one is the all-zero pattern, the result is zero.
- R4: Products that are exactly representable come out exact; for example, multiplying by 0x40 (the value 1.0 when N=8) returns the other operand unchanged.
- R5: Inexact products are rounded to the nearest posit pattern. The midpoint between two adjacent N-bit patterns p and p+1 is the value of the (N+1)-bit pattern formed by appending a 1 to p, and exact midpoints round to the pattern with an even last bit.
- R6: Magnitudes at or above maxpos (0x7F when N=8) give maxpos. Magnitudes below minpos (0x01 when N=8) give minpos. In both cases the product sign is applied, so a nonzero product never becomes zero or not-a-real.
- R7: With the register enabled, out_valid is low during and after reset until the first operand pair is taken. in_ready is high whenever the output register is empty or is being drained in the same cycle. A pair taken at a clock edge appears at the output right after that edge.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R9: Results leave in the order their operand pairs were accepted, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | N | First posit operand |
| in_b | input | N | Second posit operand |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | N | Posit product |

## Verification
Two things can happen in one cycle here. The output register can hand a result to the consumer while it loads the next operand pair. A single operand pair can also trigger both special cases, not-a-real and zero, at once. The bench runs every pair of 8-bit codes, which includes not-a-real times zero, and it lowers in_valid and out_ready at random so that drain-and-load cycles mix with stall cycles. Every drained word is compared against a queue of expected values, computed from exact real arithmetic and the (N+1)-bit midpoint rule. A mismatch therefore shows up either as a wrong special-case value or as a lost, repeated or reordered result.

// File: rtl/posit_pkg.sv
package posit_pkg;

    // Operand / result category; the arithmetic only matters for PC_NORM.
    typedef enum logic [1:0] {
        PC_NORM = 2'd0,
        PC_ZERO = 2'd1,
        PC_NAR  = 2'd2
    } pclass_e;

    // Category of a product: not-a-real dominates, then zero.
    function automatic pclass_e class_merge(input pclass_e a, input pclass_e b);
        if (a == PC_NAR || b == PC_NAR)
            return PC_NAR;
        if (a == PC_ZERO || b == PC_ZERO)
            return PC_ZERO;
        return PC_NORM;
    endfunction

endpackage

// File: rtl/posit_decode.sv
module posit_decode
    import posit_pkg::*;
#(
    parameter int N  = 8,
    parameter int ES = 1,   // ES >= 1
    parameter int SW = 8,
    localparam int FW = N - 1 - ES
) (
    input  logic [N-1:0]          x,
    output pclass_e               cls,
    output logic                  sign,
    output logic signed [SW-1:0]  scale,
    output logic [FW-1:0]         frac
);

    logic [N-1:0]  mag;
    logic [N-2:0]  body;
    logic [N-2:0]  rem;
    logic [ES-1:0] ex;
    logic          lead;
    logic          stop;
    int            run;
    int            k;

    always_comb begin
        sign = x[N-1];
        mag  = x[N-1] ? (~x + 1'b1) : x;
        body = mag[N-2:0];
        lead = body[N-2];
        run  = 0;
        stop = 1'b0;
        for (int i = N - 2; i >= 0; i--) begin
            if (!stop) begin
                if (body[i] == lead) run = run + 1;
                else                 stop = 1'b1;
            end
        end
        // drop the run and its terminating bit, left-align what remains
        rem   = body << (run + 1);
        ex    = rem[N-2 -: ES];
        frac  = rem[N-2-ES:0];
        k     = lead ? (run - 1) : -run;
        scale = SW'(k * (1 << ES) + int'(ex));

        if (x == '0)
            cls = PC_ZERO;
        else if (x == {1'b1, {(N-1){1'b0}}})
            cls = PC_NAR;
        else
            cls = PC_NORM;
    end

endmodule

// File: rtl/posit_mul_core.sv
module posit_mul_core
    import posit_pkg::*;
#(
    parameter int N  = 8,
    parameter int ES = 1,
    parameter int SW = 8,
    localparam int FW = N - 1 - ES,
    localparam int PW = 2 * FW + 2,
    localparam int PF = 2 * FW + 1
) (
    input  pclass_e               a_cls,
    input  logic                  a_sign,
    input  logic signed [SW-1:0]  a_scale,
    input  logic [FW-1:0]         a_frac,
    input  pclass_e               b_cls,
    input  logic                  b_sign,
    input  logic signed [SW-1:0]  b_scale,
    input  logic [FW-1:0]         b_frac,
    output pclass_e               p_cls,
    output logic                  p_sign,
    output logic signed [SW-1:0]  p_scale,
    output logic [PF-1:0]         p_frac
);

    logic [PW-1:0] sig_a;
    logic [PW-1:0] sig_b;
    logic [PW-1:0] prod;
    logic          ovf;

    always_comb begin
        sig_a  = {{(FW+1){1'b0}}, 1'b1, a_frac};
        sig_b  = {{(FW+1){1'b0}}, 1'b1, b_frac};
        prod   = sig_a * sig_b;           // value in [1,4) with 2*FW fraction bits
        ovf    = prod[PW-1];
        p_frac = ovf ? prod[PW-2:0] : {prod[PW-3:0], 1'b0};
        p_scale = a_scale + b_scale + {{(SW-1){1'b0}}, ovf};
        p_sign = a_sign ^ b_sign;
        p_cls  = class_merge(a_cls, b_cls);
    end

endmodule

// File: rtl/posit_encode.sv
module posit_encode
    import posit_pkg::*;
#(
    parameter int N  = 8,
    parameter int ES = 1,
    parameter int SW = 8,
    parameter int PF = 13,
    localparam int W = N + 2 + ES + PF
) (
    input  pclass_e               cls,
    input  logic                  sign,
    input  logic signed [SW-1:0]  scale,
    input  logic [PF-1:0]         frac,
    output logic [N-1:0]          y
);

    int           kk;
    int           m;
    logic [W-1:0] seed;
    logic [W-1:0] sh;
    logic [N-2:0] body;
    logic [N-2:0] bodyr;
    logic         g;
    logic         st;
    logic         up;
    logic [N-1:0] mag;

    always_comb begin
        kk = int'(scale) >>> ES;
        m  = (kk >= 0) ? kk : (-kk - 1);
        // "10" smeared right gives k+1 ones then 0; "01" gives -k zeros then 1
        seed = {((kk >= 0) ? 2'b10 : 2'b01), scale[ES-1:0], frac, {N{1'b0}}};
        sh   = W'($signed(seed) >>> m);
        body = sh[W-1 -: N-1];
        g    = sh[W-N];
        st   = |sh[W-N-1:0];
        up   = g & (st | body[0]);
        bodyr = body + {{(N-2){1'b0}}, up};
        if (kk >= N - 2)
            bodyr = '1;
        else if (kk < -(N - 2))
            bodyr = {{(N-2){1'b0}}, 1'b1};
        mag = {1'b0, bodyr};

        case (cls)
            PC_NAR:  y = {1'b1, {(N-1){1'b0}}};
            PC_ZERO: y = '0;
            default: y = sign ? (~mag + 1'b1) : mag;
        endcase
    end

endmodule

// File: rtl/posit_mul.sv
module posit_mul
    import posit_pkg::*;
#(
    parameter int N    = 8,
    parameter int ES   = 1,
    parameter bit PIPE = 1'b1,
    localparam int SW  = $clog2(N * (1 << ES)) + 3,
    localparam int FW  = N - 1 - ES,
    localparam int PF  = 2 * FW + 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [N-1:0] in_a,
    input  logic [N-1:0] in_b,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [N-1:0] out_data
);

    pclass_e              a_cls, b_cls, p_cls;
    logic                 a_sign, b_sign, p_sign;
    logic signed [SW-1:0] a_scale, b_scale, p_scale;
    logic [FW-1:0]        a_frac, b_frac;
    logic [PF-1:0]        p_frac;
    logic [N-1:0]         result;

    posit_decode #(.N(N), .ES(ES), .SW(SW)) dec_a_i (
        .x(in_a), .cls(a_cls), .sign(a_sign), .scale(a_scale), .frac(a_frac)
    );

    posit_decode #(.N(N), .ES(ES), .SW(SW)) dec_b_i (
        .x(in_b), .cls(b_cls), .sign(b_sign), .scale(b_scale), .frac(b_frac)
    );

    posit_mul_core #(.N(N), .ES(ES), .SW(SW)) core_i (
        .a_cls(a_cls), .a_sign(a_sign), .a_scale(a_scale), .a_frac(a_frac),
        .b_cls(b_cls), .b_sign(b_sign), .b_scale(b_scale), .b_frac(b_frac),
        .p_cls(p_cls), .p_sign(p_sign), .p_scale(p_scale), .p_frac(p_frac)
    );

    posit_encode #(.N(N), .ES(ES), .SW(SW), .PF(PF)) enc_i (
        .cls(p_cls), .sign(p_sign), .scale(p_scale), .frac(p_frac), .y(result)
    );

    generate
        if (PIPE) begin : g_reg
            logic         vld_q;
            logic [N-1:0] data_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q <= 1'b0;
                end else if (in_ready) begin
                    vld_q <= in_valid;
                    if (in_valid)
                        data_q <= result;
                end
            end

            assign in_ready  = !vld_q || out_ready;
            assign out_valid = vld_q;
            assign out_data  = data_q;
        end else begin : g_comb
            assign in_ready  = out_ready;
            assign out_valid = in_valid;
            assign out_data  = result;
        end
    endgenerate

endmodule

// File: rtl/posit_mul_chk.sv
module posit_mul_chk #(
    parameter int N    = 8,
    parameter bit PIPE = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic [N-1:0] in_a,
    input logic [N-1:0] in_b,
    input logic         out_valid,
    input logic         out_ready,
    input logic [N-1:0] out_data
);

    localparam logic [N-1:0] NAR_W = {1'b1, {(N-1){1'b0}}};

    logic take;
    logic a_reg;
    logic b_reg;
    assign take  = in_valid && in_ready;
    assign a_reg = (in_a != '0) && (in_a != NAR_W);
    assign b_reg = (in_b != '0) && (in_b != NAR_W);

    generate
        if (PIPE) begin : g_p
            // R2
            nar_wins_chk: assert property (@(posedge clk) disable iff (rst)
                take && (in_a == NAR_W || in_b == NAR_W) |=> out_data == NAR_W);

            // R3
            zero_out_chk: assert property (@(posedge clk) disable iff (rst)
                take && (in_a != NAR_W) && (in_b != NAR_W) && (in_a == '0 || in_b == '0)
                |=> out_data == '0);

            // R1
            sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
                take && a_reg && b_reg |=> out_data[N-1] == $past(in_a[N-1] ^ in_b[N-1]));

            // R6
            no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
                take && a_reg && b_reg |=> (out_data != '0) && (out_data != NAR_W));

            // R7
            load_shows_chk: assert property (@(posedge clk) disable iff (rst)
                take |=> out_valid);

            // R8
            stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid && !out_ready |=> out_valid && $stable(out_data));
        end
    endgenerate

endmodule

bind posit_mul posit_mul_chk #(.N(N), .PIPE(PIPE)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
);

// File: tb/posit_mul_tb_top.sv
`timescale 1ns/1ps
module posit_mul_tb_top;

    localparam int N    = 8;
    localparam int ES   = 1;
    localparam int MAXB = (1 << (N - 1)) - 1;
    localparam int NV   = 1 << (2 * N);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [N-1:0] in_a = '0;
    logic [N-1:0] in_b = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [N-1:0] out_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    real tab [0:MAXB];

    logic [N-1:0] exp_q [$];
    string        tag_q [$];

    always #2.5 clk = ~clk;

    posit_mul #(.N(N), .ES(ES), .PIPE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    // value of a positive w-bit posit pattern
    function automatic real pval(int p, int w);
        int  i;
        int  lead;
        int  run;
        int  k;
        int  e;
        int  s;
        real f;
        real wt;
        i = w - 2;
        lead = (p >> i) & 1;
        run = 0;
        while (i >= 0 && ((p >> i) & 1) == lead) begin
            run++;
            i--;
        end
        i--;
        k = lead ? run - 1 : -run;
        e = 0;
        for (int j = 0; j < ES; j++) begin
            e = e * 2;
            if (i >= 0) begin
                e += (p >> i) & 1;
                i--;
            end
        end
        f = 1.0;
        wt = 0.5;
        while (i >= 0) begin
            if (((p >> i) & 1) == 1) f += wt;
            wt = wt / 2.0;
            i--;
        end
        s = k * (1 << ES) + e;
        while (s > 0) begin f = f * 2.0; s--; end
        while (s < 0) begin f = f / 2.0; s++; end
        return f;
    endfunction

    function automatic logic [N-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b, output string tag);
        logic [N-1:0] nar;
        logic [N-1:0] ma;
        logic [N-1:0] mb;
        logic [N-1:0] r;
        logic         neg;
        real          prod;
        real          mid;
        int           bsel;
        nar = {1'b1, {(N-1){1'b0}}};
        if (a == nar || b == nar) begin tag = "R2"; return nar; end
        if (a == 0 || b == 0)     begin tag = "R3"; return '0; end
        neg = a[N-1] ^ b[N-1];
        ma = a[N-1] ? -a : a;
        mb = b[N-1] ? -b : b;
        prod = tab[ma] * tab[mb];
        if (prod >= tab[MAXB]) begin
            bsel = MAXB; tag = "R6";
        end else if (prod < tab[1]) begin
            bsel = 1; tag = "R6";
        end else begin
            bsel = 1;
            for (int q = 1; q <= MAXB; q++)
                if (tab[q] <= prod) bsel = q;
            if (tab[bsel] == prod) begin
                tag = (ma == 8'h40 || mb == 8'h40) ? "R4" : (neg ? "R1" : "R5");
            end else begin
                mid = pval((bsel << 1) | 1, N + 1);
                tag = neg ? "R1" : "R5";
                if (prod > mid) bsel = bsel + 1;
                else if (prod == mid && (bsel % 2 == 1)) bsel = bsel + 1;
            end
        end
        r = N'(bsel);
        return neg ? -r : r;
    endfunction

    task automatic check(bit ok, string req, logic [N-1:0] act, logic [N-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL R9 watchdog expired, actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int           idx;
        bit           hold_prev;
        logic [N-1:0] held;
        logic [N-1:0] ev;
        string        tg;

        for (int q = 0; q <= MAXB; q++) tab[q] = (q == 0) ? 0.0 : pval(q, N);

        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7", {7'b0, out_valid}, '0);
        rst = 1'b0;

        idx = 0;
        hold_prev = 0;
        held = '0;
        while (idx < NV || exp_q.size() > 0) begin
            @(negedge clk);
            if (hold_prev)
                check(out_valid && out_data == held, "R8", out_data, held);
            in_valid  = (idx < NV) && ($urandom % 8 != 0);
            in_a      = N'(idx >> N);
            in_b      = N'(idx);
            out_ready = (idx >= NV) || ($urandom % 8 != 0);
            #1;
            check(in_ready == (!out_valid || out_ready), "R7",
                  {7'b0, in_ready}, {7'b0, (!out_valid || out_ready)});
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", out_data, 'x);
                end else begin
                    ev = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    check(out_data == ev, tg, out_data, ev);
                end
            end
            if (in_valid && in_ready) begin
                ev = ref_mul(in_a, in_b, tg);
                exp_q.push_back(ev);
                tag_q.push_back(tg);
                idx++;
            end
            hold_prev = out_valid && !out_ready;
            held = out_data;
        end

        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(out_valid == 1'b0, "R9", {7'b0, out_valid}, '0);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule